// File: doc/BRIEF.md
# NAND Controller Event Status and Interrupt Register

This block holds the event status word of a NAND flash controller and drives its single interrupt line. Single-cycle strobes from the rest of the controller (chip ready, per-chip-select page and command completion, bad-block detection, ECC error classes, data and command-buffer requests) set sticky bits in a 13-bit status word. Software reads that word over a simple register port and acknowledges events by writing ones to the bits it has handled. A 12-bit mask field held in the control register decides which of the twelve clearable events may raise the interrupt. A 1 in a mask bit blocks its source, and every source is blocked out of reset.

The register port is a plain synchronous bus: one address, a write enable and write data that are sampled on the rising clock edge, and read data that follows the address without delay. Reading has no side effects. The control word sits at offset 0x00 and the status word at offset 0x14. All other offsets read as zero and ignore writes. A separate pulse marks the point where the controller clock has been restarted after a gated period. On that pulse the status word takes a fixed restart value in which only the two ready bits are set.

Top module: `nsr_status_irq`

## Requirements
- R1: After reset the status word is 0, all twelve mask bits are 1 (control reads 0x0000_0FFF) and `irq` is 0.
- R2: A 1 on `evt_set[i]` sets status bit i at the next rising edge, and the bit then holds until it is cleared or the restart pulse arrives. Bit positions are: 12 ready, 11 flash ready, 10 and 9 page done for chip select 0 and 1, 8 and 7 command done for chip select 0 and 1, 6 and 5 bad block for chip select 0 and 1, 4 double-bit ECC error, 3 single-bit ECC error, 2 write-data request, 1 read-data request, 0 command-buffer request.
- R3: A write to offset 0x14 clears each status bit in 11..0 whose write-data bit is 1 and leaves bits written with 0 unchanged. Bit 12 is not affected by any write.
- R4: When a set strobe and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R5: A pulse on `clk_restart` makes the status word exactly 0x1800 at the next edge, whatever set strobes or clears occur in the same cycle.
- R6: A write to offset 0x00 loads `bus_wdata[11:0]` into the mask bits. A read of offset 0x00 returns the mask bits with bits 31..12 zero.
- R7: `irq` is 1 exactly one cycle after some status bit in 11..0 is 1 while its mask bit is 0. Status bit 12 never raises `irq`.
- R8: A read of offset 0x14 returns the status word in bits 12..0 with bits 31..13 zero. Any other offset reads 0, and writes to it change neither status nor masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, rising-edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write enable, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_set | input | 13 | Event set strobes, one per status bit |
| clk_restart | input | 1 | Pulse marking a controller clock restart |
| irq | output | 1 | Registered interrupt request |

## Verification
The embedded assertions check several rules on every clock cycle: a strobed bit is set one edge later, an acknowledged bit with no competing strobe is clear one edge later, a bit that is both set and cleared in the same cycle ends up set, the restart pulse forces the fixed word, a control write loads the masks, and `irq` follows the masked status with one cycle of lag. Only the bench scenarios can show the behaviour seen from the bus. This covers the zero upper bits in read data, the fact that writes to unused offsets have no effect, that bit 12 ignores writes and never raises the interrupt, and how all of these interact under a long random mix of strobes, acknowledgements, mask changes and restart pulses, checked against an independent model.

// File: rtl/nsr_pkg.sv
package nsr_pkg;
  localparam int NSR_STAT_W  = 13;
  localparam int NSR_SRC_W   = 12;
  localparam int NSR_RDY_BIT  = 12;
  localparam int NSR_FRDY_BIT = 11;
  localparam logic [NSR_STAT_W-1:0] NSR_RESTART_VAL =
    NSR_STAT_W'((1 << NSR_RDY_BIT) | (1 << NSR_FRDY_BIT));
  localparam logic [NSR_SRC_W-1:0] NSR_MASK_RESET = '1;
endpackage

// File: rtl/nsr_regdec.sv
module nsr_regdec #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 'h00,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h14
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  output logic              ctrl_hit_o,
  output logic              stat_hit_o,
  output logic              ctrl_wr_o,
  output logic              stat_wr_o
);
  always_comb begin
    ctrl_hit_o = (addr_i == CTRL_OFS);
    stat_hit_o = (addr_i == STAT_OFS);
    ctrl_wr_o  = we_i && ctrl_hit_o;
    stat_wr_o  = we_i && stat_hit_o;
  end
endmodule

// File: rtl/nsr_status_bank.sv
module nsr_status_bank #(
  parameter int STAT_W = 13,
  parameter int SRC_W  = 12,
  parameter logic [STAT_W-1:0] RESTART_VAL = 13'h1800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set_i,
  input  logic              clr_en_i,
  input  logic [SRC_W-1:0]  clr_bits_i,
  input  logic              restart_i,
  output logic [STAT_W-1:0] stat_o
);
  localparam int FIXED_W = STAT_W - SRC_W;

  logic [STAT_W-1:0] clr_ext;

  // only the low SRC_W bits accept write-1 clears
  assign clr_ext = {{FIXED_W{1'b0}}, (clr_en_i ? clr_bits_i : {SRC_W{1'b0}})};

  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            stat_o[i] <= 1'b0;
      else if (restart_i)    stat_o[i] <= RESTART_VAL[i];
      else if (set_i[i])     stat_o[i] <= 1'b1;   // set wins over clear
      else if (clr_ext[i])   stat_o[i] <= 1'b0;
    end
  end

  assert_set_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart_i && |set_i) |=> ((stat_o & $past(set_i)) == $past(set_i)));

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart_i && |(clr_ext & ~set_i)) |=> ((stat_o & $past(clr_ext & ~set_i)) == '0));

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart_i && |(clr_ext & set_i)) |=> ((stat_o & $past(clr_ext & set_i)) == $past(clr_ext & set_i)));

  assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (stat_o == RESTART_VAL));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart_i && set_i == '0 && clr_ext == '0) |=> $stable(stat_o));
endmodule

// File: rtl/nsr_mask_reg.sv
module nsr_mask_reg #(
  parameter int SRC_W = 12,
  parameter logic [SRC_W-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [SRC_W-1:0] wdata_i,
  output logic [SRC_W-1:0] mask_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_o <= RESET_VAL;
    else if (wr_i) mask_o <= wdata_i;
  end

  assert_mask_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (mask_o == $past(wdata_i)));

  assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(mask_o));
endmodule

// File: rtl/nsr_irq_out.sv
module nsr_irq_out #(
  parameter int SRC_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] src_i,
  input  logic [SRC_W-1:0] mask_i,
  output logic             irq_o
);
  logic [SRC_W-1:0] live;

  assign live = src_i & ~mask_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |live;
  end

  assert_irq_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (live != '0) |=> irq_o);

  assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (live == '0) |=> !irq_o);
endmodule

// File: rtl/nsr_status_irq.sv
module nsr_status_irq
  import nsr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 'h00,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h14
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_we,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic [NSR_STAT_W-1:0] evt_set,
  input  logic                  clk_restart,
  output logic                  irq
);
  logic ctrl_hit, stat_hit, ctrl_wr, stat_wr;
  logic [NSR_STAT_W-1:0] stat_q;
  logic [NSR_SRC_W-1:0]  mask_q;
  logic unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NSR_SRC_W];

  nsr_regdec #(.ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .STAT_OFS(STAT_OFS)) u_dec (
    .addr_i(bus_addr), .we_i(bus_we),
    .ctrl_hit_o(ctrl_hit), .stat_hit_o(stat_hit),
    .ctrl_wr_o(ctrl_wr), .stat_wr_o(stat_wr)
  );

  nsr_status_bank #(.STAT_W(NSR_STAT_W), .SRC_W(NSR_SRC_W), .RESTART_VAL(NSR_RESTART_VAL)) u_bank (
    .clk(clk), .rst_n(rst_n), .set_i(evt_set),
    .clr_en_i(stat_wr), .clr_bits_i(bus_wdata[NSR_SRC_W-1:0]),
    .restart_i(clk_restart), .stat_o(stat_q)
  );

  nsr_mask_reg #(.SRC_W(NSR_SRC_W), .RESET_VAL(NSR_MASK_RESET)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_i(ctrl_wr),
    .wdata_i(bus_wdata[NSR_SRC_W-1:0]), .mask_o(mask_q)
  );

  nsr_irq_out #(.SRC_W(NSR_SRC_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .src_i(stat_q[NSR_SRC_W-1:0]),
    .mask_i(mask_q), .irq_o(irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (ctrl_hit)      bus_rdata[NSR_SRC_W-1:0]  = mask_q;
    else if (stat_hit) bus_rdata[NSR_STAT_W-1:0] = stat_q;
  end

  assert_read_ctrl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_hit |-> (bus_rdata[DATA_W-1:NSR_SRC_W] == '0));

  assert_read_stat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_hit |-> (bus_rdata[DATA_W-1:NSR_STAT_W] == '0));
endmodule

// File: tb/sim_nsr_status_irq.sv
`timescale 1ns/1ps
module sim_nsr_status_irq;
  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_STAT = 8'h14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [12:0] evt_set = '0;
  logic        clk_restart = 1'b0;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [12:0] m_stat;
  logic [11:0] m_mask;
  logic        m_irq;

  always #2.5 clk = ~clk;

  nsr_status_irq u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_set(evt_set),
    .clk_restart(clk_restart), .irq(irq)
  );

  function automatic logic [31:0] model_read(input logic [7:0] a);
    if (a == A_CTRL) return {20'h0, m_mask};
    if (a == A_STAT) return {19'h0, m_stat};
    return 32'h0;
  endfunction

  function automatic logic [12:0] model_next(input logic [12:0] ev, input logic rs,
                                              input logic we, input logic [7:0] a,
                                              input logic [31:0] wd);
    logic [12:0] clr;
    clr = (we && a == A_STAT) ? {1'b0, wd[11:0]} : 13'h0;
    if (rs) return 13'h1800;
    return (m_stat & ~clr) | ev;
  endfunction

  task automatic chk(input string req, input string scen, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s [%s] actual=%h expected=%h", req, scen, act, exp);
    end
  endtask

  task automatic step(input logic [12:0] ev, input logic rs, input logic we,
                      input logic [7:0] a, input logic [31:0] wd, input string scen);
    logic nirq;
    @(negedge clk);
    evt_set = ev; clk_restart = rs; bus_we = we; bus_addr = a; bus_wdata = wd;
    #1;
    chk((a == A_CTRL) ? "R6" : "R8", scen, bus_rdata, model_read(a));
    nirq = |(m_stat[11:0] & ~m_mask);
    m_stat = model_next(ev, rs, we, a, wd);
    if (we && a == A_CTRL) m_mask = wd[11:0];
    m_irq = nirq;
    @(posedge clk);
    #1;
    chk("R7", scen, {31'h0, irq}, {31'h0, m_irq});
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [12:0] ev;
    logic [7:0]  a;
    logic        rs, we;
    int          sel;
    m_stat = '0; m_mask = 12'hFFF; m_irq = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state seen while reset is held
    chk("R1", "reset irq", {31'h0, irq}, 32'h0);
    bus_addr = A_CTRL; #1;
    chk("R1", "reset masks", bus_rdata, 32'h0000_0FFF);
    bus_addr = A_STAT; #1;
    chk("R1", "reset status", bus_rdata, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // R2: strobe sets a bit that then stays set
    step(13'h0008, 0, 0, A_STAT, 0, "R2 set bit3");
    step(13'h0000, 0, 0, A_STAT, 0, "R2 sticky");
    step(13'h1000, 0, 0, A_STAT, 0, "R2 set bit12");
    step(13'h0000, 0, 0, A_STAT, 0, "R2 readback");
    // R3: write-1 clears low bits only, zeros keep
    step(13'h0000, 0, 1, A_STAT, 32'h0000_0000, "R3 zero write");
    step(13'h0000, 0, 1, A_STAT, 32'hFFFF_FFFF, "R3 clear all");
    step(13'h0000, 0, 0, A_STAT, 0, "R3 bit12 kept");
    // R4: set and clear in the same cycle
    step(13'h0020, 0, 1, A_STAT, 32'h0000_0020, "R4 collide");
    step(13'h0000, 0, 0, A_STAT, 0, "R4 readback");
    // R6: mask load with junk upper bits, then unmask bit5 for R7
    step(13'h0000, 0, 1, A_CTRL, 32'hABCD_EFDF, "R6 mask write");
    step(13'h0000, 0, 0, A_CTRL, 0, "R6 readback");
    step(13'h0000, 0, 0, A_STAT, 0, "R7 irq high");
    // R7: bit12 alone never interrupts
    step(13'h0000, 0, 1, A_CTRL, 32'h0000_0000, "R7 unmask all");
    step(13'h0000, 0, 1, A_STAT, 32'h0000_0FFF, "R7 clear low");
    step(13'h1000, 0, 0, A_STAT, 0, "R7 bit12 only");
    step(13'h0000, 0, 0, A_STAT, 0, "R7 quiet");
    // R5: restart beats strobes and clears
    step(13'h07FF, 1, 1, A_STAT, 32'h0000_1800, "R5 restart");
    step(13'h0000, 0, 0, A_STAT, 0, "R5 readback");
    // R8: unused offset ignores writes and reads zero
    step(13'h0000, 0, 1, 8'h08, 32'hFFFF_FFFF, "R8 odd write");
    step(13'h0000, 0, 0, A_STAT, 0, "R8 status kept");
    step(13'h0000, 0, 0, A_CTRL, 0, "R8 masks kept");

    void'($urandom(32'h5EED_0001));
    for (int n = 0; n < 600; n++) begin
      ev  = 13'($urandom() & $urandom() & $urandom());
      rs  = ($urandom_range(31) == 0);
      we  = ($urandom_range(3) == 0);
      sel = $urandom_range(5);
      a   = (sel < 2) ? A_CTRL : (sel < 5) ? A_STAT : 8'($urandom_range(255));
      step(ev, rs, we, a, $urandom(), "random");
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule